// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a 32-bit core that gives each procedure its own register window. An instruction names one of 32 architectural registers with a 5-bit number. The block maps that number onto a larger physical array through a window pointer, so a call or a return changes which storage is visible without copying any register.

The 32 visible registers fall into four groups of eight. Numbers 0–7 are globals, and every window shares them. Numbers 16–23 are locals, private to the window. Numbers 24–31 are the inbound argument group. Numbers 8–15 are the outbound argument group. The outbound group of one window is the same storage as the inbound group of the next window. When a caller places arguments in 8–15 and then moves the window forward, the callee finds those arguments in 24–31.

Moving forward (save) or back (restore) is refused at the edges of the live window stack. A one-cycle flag then tells the surrounding core that a spill or a fill to memory is needed. The core runs that routine itself. All ports are plain control and data pins with no handshake. Every input is acted on in the cycle it is presented, and nothing can stall the block.

Top module: `wrf_top`

## Requirements
- R1: After reset, every architectural register reads as zero, both flags are low, and the window pointer equals NWIN-1.
- R2: Architectural register 0 always reads as zero. A write to it is discarded.
- R3: A write lands at the clock edge. A read in the same cycle as the write returns the old value, and a read in any later cycle returns the new value.
- R4: Registers 0–7 name the same storage in every window.
- R5: A save request with no restore request advances the pointer by one, modulo NWIN, unless an overflow occurs. Registers 8–15 of the old window then appear as registers 24–31 of the new window, with the same storage.
- R6: Registers 16–23 are private to each window. A fresh window shows its own locals, and a restore brings back the caller's locals unchanged.
- R7: A restore request with no save request moves the pointer back by one, modulo NWIN (0 goes to NWIN-1), unless an underflow occurs.
- R8: A save made while NWIN-1 windows are live raises the overflow flag for exactly the next cycle and leaves the pointer unchanged.
- R9: A restore made while only one window is live raises the underflow flag for exactly the next cycle and leaves the pointer unchanged.
- R10: Save and restore requested in the same cycle are both ignored: the pointer does not change and neither flag is raised.
- R11: A write made in the same cycle as a save goes to the window that was current before the save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_addr_a | input | 5 | Architectural number for read port A |
| rd_data_a | output | DW | Read data A, combinational |
| rd_addr_b | input | 5 | Architectural number for read port B |
| rd_data_b | output | DW | Read data B, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural number to write |
| wr_data | input | DW | Write data |
| win_save | input | 1 | Request to advance the window |
| win_restore | input | 1 | Request to move the window back |
| win_ptr | output | $clog2(NWIN) | Current window pointer |
| win_ovf | output | 1 | One-cycle pulse: the last save was refused and a spill is needed |
| win_unf | output | 1 | One-cycle pulse: the last restore was refused and a fill is needed |

## Verification
Read data is combinational, so a read is due in the same cycle its address is driven. A write becomes visible from the cycle after the edge that takes it. The pointer and both flags reflect a request one edge after it was presented. The driver sets inputs on the falling edge. The monitor compares each queued expectation 2 ns later: read expectations go into the item of the cycle that carries the address, and pointer and flag expectations go into the item of the following cycle.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int GLB_REGS = 8;   // shared global set
  localparam int WIN_REGS = 16;  // locals + inbound group per window
  localparam int GRP_SIZE = 8;

  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } grp_e;
endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int CW   = 3,
  parameter int PW   = 8
) (
  input  logic [CW-1:0] cwp,
  input  logic [4:0]    arch,
  output logic [PW-1:0] phys
);
  grp_e          grp;
  logic [CW-1:0] nxt;
  int            slot;

  always_comb begin
    grp  = grp_e'(arch[4:3]);
    slot = int'(arch[2:0]);
    nxt  = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
    case (grp)
      GRP_GLB: phys = PW'(slot);
      GRP_LOC: phys = PW'(GLB_REGS + WIN_REGS * int'(cwp) + slot);
      GRP_IN:  phys = PW'(GLB_REGS + WIN_REGS * int'(cwp) + GRP_SIZE + slot);
      GRP_OUT: phys = PW'(GLB_REGS + WIN_REGS * int'(nxt) + GRP_SIZE + slot);
      default: phys = '0;
    endcase
  end
endmodule

// File: rtl/wrf_ctl.sv
module wrf_ctl #(
  parameter int NWIN = 8,
  parameter int CW   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save,
  input  logic          restore,
  output logic [CW-1:0] cwp,
  output logic          ovf,
  output logic          unf
);
  localparam int LW = $clog2(NWIN + 1);

  logic [LW-1:0] live;
  logic [CW-1:0] cwp_up, cwp_dn;

  assign cwp_up = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
  assign cwp_dn = (cwp == '0) ? CW'(NWIN - 1) : cwp - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp  <= CW'(NWIN - 1);
      live <= LW'(1);
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (save && !restore) begin
        if (live == LW'(NWIN - 1)) begin
          ovf <= 1'b1;
        end else begin
          cwp  <= cwp_up;
          live <= live + LW'(1);
        end
      end else if (restore && !save) begin
        if (live == LW'(1)) begin
          unf <= 1'b1;
        end else begin
          cwp  <= cwp_dn;
          live <= live - LW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int DW   = 32,
  parameter int PHYS = 136,
  parameter int PW   = 8,
  parameter int NRD  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr [NRD],
  input  logic          rzero [NRD],
  output logic [DW-1:0] rdata [NRD]
);
  logic [DW-1:0] mem [PHYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHYS; i++) mem[i] <= '0;
    end else if (we && waddr != '0) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = rzero[g] ? '0 : mem[raddr[g]];
  end
endmodule

// File: rtl/wrf_top.sv
module wrf_top
  import wrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              rd_addr_a,
  output logic [DW-1:0]           rd_data_a,
  input  logic [4:0]              rd_addr_b,
  output logic [DW-1:0]           rd_data_b,
  input  logic                    wr_en,
  input  logic [4:0]              wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    win_save,
  input  logic                    win_restore,
  output logic [$clog2(NWIN)-1:0] win_ptr,
  output logic                    win_ovf,
  output logic                    win_unf
);
  localparam int CW    = $clog2(NWIN);
  localparam int PHYS  = GLB_REGS + WIN_REGS * NWIN;
  localparam int PW    = $clog2(PHYS);
  localparam int NPORT = 3;  // two reads + one write

  logic [CW-1:0] cwp;
  logic [4:0]    arch  [NPORT];
  logic [PW-1:0] phys  [NPORT];
  logic [PW-1:0] raddr [2];
  logic          rzero [2];
  logic [DW-1:0] rdata [2];

  assign arch[0] = rd_addr_a;
  assign arch[1] = rd_addr_b;
  assign arch[2] = wr_addr;

  wrf_ctl #(.NWIN(NWIN), .CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .save(win_save), .restore(win_restore),
    .cwp(cwp), .ovf(win_ovf), .unf(win_unf)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_xl
    wrf_xlate #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_xl (
      .cwp(cwp), .arch(arch[g]), .phys(phys[g])
    );
  end

  for (genvar g = 0; g < 2; g++) begin : g_rp
    assign raddr[g] = phys[g];
    assign rzero[g] = (arch[g] == 5'd0);
  end

  wrf_store #(.DW(DW), .PHYS(PHYS), .PW(PW), .NRD(2)) u_st (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(phys[2]), .wdata(wr_data),
    .raddr(raddr), .rzero(rzero), .rdata(rdata)
  );

  assign rd_data_a = rdata[0];
  assign rd_data_b = rdata[1];
  assign win_ptr   = cwp;
endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [4:0]              rd_addr_a,
  input logic [DW-1:0]           rd_data_a,
  input logic [4:0]              rd_addr_b,
  input logic [DW-1:0]           rd_data_b,
  input logic                    win_save,
  input logic                    win_restore,
  input logic [$clog2(NWIN)-1:0] win_ptr,
  input logic                    win_ovf,
  input logic                    win_unf
);
  localparam int CW = $clog2(NWIN);

  AST_ZERO_RD_A: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == 5'd0) |-> (rd_data_a == '0)); // R2
  AST_ZERO_RD_B: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_b == 5'd0) |-> (rd_data_b == '0)); // R2
  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (win_save && !win_restore) |=> (win_ovf ||
      win_ptr == (($past(win_ptr) == CW'(NWIN - 1)) ? '0 : $past(win_ptr) + CW'(1)))); // R5
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (rst)
    (win_restore && !win_save) |=> (win_unf ||
      win_ptr == (($past(win_ptr) == '0) ? CW'(NWIN - 1) : $past(win_ptr) - CW'(1)))); // R7
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    win_ovf |-> (win_ptr == $past(win_ptr))); // R8
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
    win_unf |-> (win_ptr == $past(win_ptr))); // R9
  AST_BOTH_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (win_save && win_restore) |=> (!win_ovf && !win_unf && $stable(win_ptr))); // R10
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(win_ovf && win_unf)); // R8
endmodule

bind wrf_top wrf_chk #(.NWIN(NWIN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
  .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .win_save(win_save),
  .win_restore(win_restore), .win_ptr(win_ptr), .win_ovf(win_ovf),
  .win_unf(win_unf)
);

// File: tb/sim_wrf_top.sv
`timescale 1ns/1ps
module sim_wrf_top;
  localparam int NWIN = 8;
  localparam int DW   = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    rd_addr_a, rd_addr_b, wr_addr;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data;
  logic          wr_en, win_save, win_restore;
  logic [2:0]    win_ptr;
  logic          win_ovf, win_unf;

  always #5 clk = ~clk;

  wrf_top #(.NWIN(NWIN), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .win_save(win_save),
    .win_restore(win_restore), .win_ptr(win_ptr), .win_ovf(win_ovf),
    .win_unf(win_unf)
  );

  typedef struct {
    bit          ca;
    logic [31:0] ea;
    bit          cb;
    logic [31:0] eb;
    bit          cf;
    bit          eo;
    bit          eu;
    logic [2:0]  ep;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  bit   summary_done = 0;

  function automatic exp_t ex(bit ca, logic [31:0] ea, bit cb, logic [31:0] eb,
                              bit cf, bit eo, bit eu, logic [2:0] ep, string tag);
    exp_t e;
    e.ca = ca; e.ea = ea; e.cb = cb; e.eb = eb;
    e.cf = cf; e.eo = eo; e.eu = eu; e.ep = ep; e.tag = tag;
    return e;
  endfunction

  function automatic exp_t none();
    return ex(0, '0, 0, '0, 0, 0, 0, '0, "");
  endfunction

  // driver: inputs on the falling edge, expectation for this cycle queued
  task automatic tick(input bit we, input logic [4:0] wa, input logic [31:0] wd,
                      input bit sv, input bit rs, input logic [4:0] ra,
                      input logic [4:0] rb, input exp_t e);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    win_save = sv; win_restore = rs;
    rd_addr_a = ra; rd_addr_b = rb;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // monitor: compares 2 ns after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.ca) cmp(e.tag, "rd_data_a", rd_data_a, e.ea);
        if (e.cb) cmp(e.tag, "rd_data_b", rd_data_b, e.eb);
        if (e.cf) begin
          cmp(e.tag, "win_ovf", 32'(win_ovf), 32'(e.eo));
          cmp(e.tag, "win_unf", 32'(win_unf), 32'(e.eu));
          cmp(e.tag, "win_ptr", 32'(win_ptr), 32'(e.ep));
        end
      end
    end
  end

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  localparam logic [31:0] A1  = 32'hA1A1_0001;
  localparam logic [31:0] C8  = 32'hC0C0_0008;
  localparam logic [31:0] C9  = 32'hC0C0_0009;
  localparam logic [31:0] L16 = 32'h1111_0016;
  localparam logic [31:0] L2  = 32'h2222_0016;
  localparam logic [31:0] I24 = 32'h2424_0024;

  initial begin
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0;
    win_save = 0; win_restore = 0; rd_addr_a = 0; rd_addr_b = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    tick(0, 0, 0, 0, 0, 0, 5, ex(1, 0, 1, 0, 1, 0, 0, 3'd7, "R1"));
    tick(0, 0, 0, 0, 0, 20, 27, ex(1, 0, 1, 0, 0, 0, 0, 0, "R1"));
    // R3: same-cycle read returns the old value, later read the new one
    tick(1, 5'd1, A1, 0, 0, 1, 0, ex(1, 0, 0, 0, 0, 0, 0, 0, "R3"));
    tick(1, 5'd0, 32'hDEAD_BEEF, 0, 0, 1, 0, ex(1, A1, 0, 0, 0, 0, 0, 0, "R3"));
    // R2: write to register 0 was discarded
    tick(0, 0, 0, 0, 0, 0, 0, ex(1, 0, 1, 0, 0, 0, 0, 0, "R2"));
    tick(1, 5'd8,  C8,  0, 0, 0, 0, none());
    tick(1, 5'd16, L16, 0, 0, 0, 0, none());
    tick(1, 5'd24, I24, 0, 0, 0, 0, none());
    // save with a simultaneous write to 9 (R11)
    tick(1, 5'd9, C9, 1, 0, 0, 0, ex(0, 0, 0, 0, 1, 0, 0, 3'd7, "R5"));
    // R5, R11: caller outputs appear as callee inputs; pointer wraps 7 -> 0
    tick(0, 0, 0, 0, 0, 24, 25, ex(1, C8, 1, C9, 1, 0, 0, 3'd0, "R5 R11"));
    // R6 fresh locals, R4 shared globals
    tick(1, 5'd16, L2, 0, 0, 16, 1, ex(1, 0, 1, A1, 0, 0, 0, 0, "R6 R4"));
    tick(0, 0, 0, 0, 1, 16, 0, ex(1, L2, 0, 0, 0, 0, 0, 0, "R6"));
    // R7, R6: back in caller window 7
    tick(0, 0, 0, 0, 0, 16, 8, ex(1, L16, 1, C8, 1, 0, 0, 3'd7, "R7 R6"));
    // R9: underflow with one live window
    tick(0, 0, 0, 0, 1, 0, 0, none());
    tick(0, 0, 0, 0, 0, 24, 0, ex(1, I24, 0, 0, 1, 0, 1, 3'd7, "R9"));
    tick(0, 0, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 1, 0, 0, 3'd7, "R9"));
    // R10: both requests together
    tick(0, 0, 0, 1, 1, 0, 0, none());
    tick(0, 0, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 1, 0, 0, 3'd7, "R10"));
    // R5 stepping and R8 overflow
    for (int i = 0; i < 7; i++) begin
      tick(0, 0, 0, 1, 0, 0, 0,
           ex(0, 0, 0, 0, 1, 0, 0, (i == 0) ? 3'd7 : 3'(i - 1), "R5"));
    end
    tick(0, 0, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 1, 1, 0, 3'd5, "R8"));
    tick(0, 0, 0, 0, 0, 0, 0, ex(0, 0, 0, 0, 1, 0, 0, 3'd5, "R8"));
    // R7 stepping back; window 0 keeps its own locals (R6)
    for (int j = 0; j < 6; j++) begin
      tick(0, 0, 0, 0, 1, (j == 5) ? 5'd16 : 5'd0, 0,
           ex(1, (j == 5) ? L2 : 32'h0, 0, 0, 1, 0, 0, 3'(5 - j), "R7 R6"));
    end
    tick(0, 0, 0, 0, 0, 16, 1, ex(1, L16, 1, A1, 1, 0, 0, 3'd7, "R7 R6 R4"));
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule